// File: doc/BRIEF.md
# Sign-Steered Cross-Correlation Accumulator

This block accumulates the correlation between one bit interval of received chip samples and the binary symbols of K users. Each interval brings N signed 8-bit samples per part (real and imaginary) and one symbol bit per user. For every user k and chip n, the block adds chip n into the entry (k, n) of its correlation matrix. When the user's symbol is -1 it subtracts the chip instead. No multiplier is used: the 1-bit symbol only picks whether the chip is added or negated before the add.

A bank of N adders per part serves one user per clock cycle, so one interval takes K cycles. The block latches the interval's inputs when it accepts a start. It raises busy for the sweep and pulses done when the matrix is up to date. Over successive intervals the matrix grows into a windowed correlation. A clear request zeroes it before a new window. The accumulators are wider than the samples and saturate at their limits. A registered read port returns any entry of either part.

Top module: `xcorr_accum`

## Requirements
- R1: After a synchronous active-low reset, busy and done are 0 and every entry of both parts reads 0.
- R2: Symbol bit k of `sym` belongs to user k, and chip n of a sample vector occupies bits [8n+7:8n] as a two's-complement value. A symbol bit of 0 adds chip n to entry (k, n). A symbol bit of 1 subtracts it.
- R3: The real and imaginary parts are accumulated in separate matrices from their own sample vectors, and both are steered by the same symbol bit.
- R4: A start accepted while idle raises busy in the next cycle and holds it for exactly K cycles. done is a one-cycle pulse in the first cycle that busy is low again.
- R5: Without a clear, successive intervals add onto the values left by earlier intervals.
- R6: A clear request while idle sets every entry of both parts to 0. If start is requested in the same cycle, the new interval accumulates onto zeros.
- R7: While busy, start and clear requests are ignored, and changes on the sample and symbol inputs have no effect on the interval in progress.
- R8: An entry that would pass the largest positive value of the accumulator width holds that value, and one that would pass the most negative value holds that value. The width is the sample width plus ceil(log2(WINDOW+1)).
- R9: The entry addressed by `rd_user` and `rd_chip` appears on `rd_re` and `rd_im` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to accumulate one bit interval |
| clear | input | 1 | Request to zero both correlation matrices |
| smp_re | input | N*SAMP_W | Real chip samples, chip n in bits [8n+7:8n] |
| smp_im | input | N*SAMP_W | Imaginary chip samples, same layout |
| sym | input | K | Symbol bit per user, 0 = +1, 1 = -1 |
| busy | output | 1 | High while the user sweep runs |
| done | output | 1 | One-cycle pulse when the sweep has finished |
| rd_user | input | UW | Read address, user index |
| rd_chip | input | CW | Read address, chip index |
| rd_re | output | ACC_W | Real entry at the read address, one cycle later |
| rd_im | output | ACC_W | Imaginary entry at the read address, one cycle later |

## Verification
The bench builds the block with K=4, N=4 and WINDOW=4. This gives 11-bit accumulators and a 16-entry matrix per part, so the bench can read back every entry after each interval. With these sizes, nine full-scale intervals of -128 chips reach both saturation limits within a short run: users whose symbol is -1 hit the positive limit and the others hit the negative limit. The short four-cycle sweep also leaves room to inject start, clear and new input values in the middle of a sweep, and to reset during a sweep.

// File: rtl/xcorr_pkg.sv
// Shared types for the sign-steered cross-correlation accumulator.
// Assumes: two parts (real, imaginary) are always processed side by side.
package xcorr_pkg;

    // Number of parallel parts handled by separate lanes.
    localparam int NUM_PARTS = 2;

    // Part index used by the generate loops.
    typedef enum int {
        PART_RE = 0,
        PART_IM = 1
    } xc_part_e;

    // Sweep controller states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xc_state_e;

endpackage

// File: rtl/xcorr_lane.sv
// One part's adder bank: N sign-steered saturating adders that update
// one user's row of the correlation matrix in a single cycle.
// Assumes: ACC_W > SAMP_W, so a negated most-negative sample fits.
module xcorr_lane #(
    parameter int N      = 16,
    parameter int SAMP_W = 8,
    parameter int ACC_W  = 15
) (
    input  logic                  neg,
    input  logic [N*SAMP_W-1:0]   samples,
    input  logic [N*ACC_W-1:0]    row_in,
    output logic [N*ACC_W-1:0]    row_out
);

    localparam int EXT_W = ACC_W + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    for (genvar g = 0; g < N; g++) begin : g_chip
        logic [EXT_W-1:0] ext;
        logic [EXT_W-1:0] opnd;
        logic [EXT_W-1:0] acc_ext;
        logic [EXT_W-1:0] sum;
        logic [ACC_W-1:0] res;

        // Sign-extend the chip, negate it for a -1 symbol, add and clamp.
        always_comb begin
            ext     = {{(EXT_W-SAMP_W){samples[g*SAMP_W+SAMP_W-1]}},
                       samples[g*SAMP_W +: SAMP_W]};
            opnd    = neg ? (~ext + EXT_W'(1)) : ext;
            acc_ext = {row_in[g*ACC_W+ACC_W-1], row_in[g*ACC_W +: ACC_W]};
            sum     = acc_ext + opnd;
            if (sum[ACC_W] != sum[ACC_W-1]) begin
                res = sum[ACC_W] ? ACC_MIN : ACC_MAX;
            end else begin
                res = sum[ACC_W-1:0];
            end
        end

        assign row_out[g*ACC_W +: ACC_W] = res;
    end

endmodule

// File: rtl/xcorr_bank.sv
// Storage for one part's K x N correlation matrix: row-wide write of the
// swept user, a combinational row view for the adders, a bulk clear and a
// registered single-entry read port.
// Assumes: clear and write never coincide (the controller guarantees it).
module xcorr_bank #(
    parameter int K     = 8,
    parameter int N     = 16,
    parameter int ACC_W = 15,
    parameter int UW    = 3,
    parameter int CW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [UW-1:0]        cur_user,
    input  logic [N*ACC_W-1:0]   wr_row,
    output logic [N*ACC_W-1:0]   cur_row,
    input  logic [UW-1:0]        rd_user,
    input  logic [CW-1:0]        rd_chip,
    output logic [ACC_W-1:0]     rd_data
);

    logic [N*ACC_W-1:0] rows [K];

    // Row seen by the adder bank for the user being swept.
    assign cur_row = rows[cur_user];

    // Matrix storage: reset and clear zero it, a sweep step replaces one row.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < K; k++) begin
                rows[k] <= '0;
            end
        end else if (wr_en) begin
            rows[cur_user] <= wr_row;
        end
    end

    // Registered read of one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rows[rd_user][int'(rd_chip)*ACC_W +: ACC_W];
        end
    end

endmodule

// File: rtl/xcorr_ctrl.sv
// Sweep controller: accepts start or clear while idle, then steps the user
// index through 0..K-1, one user per cycle, and pulses done at the end.
// Assumes: K >= 1; requests arriving while running are dropped.
module xcorr_ctrl
    import xcorr_pkg::*;
#(
    parameter int K  = 8,
    parameter int UW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clear,
    output logic          busy,
    output logic          done,
    output logic [UW-1:0] user,
    output logic          upd_en,
    output logic          clr_en,
    output logic          cap_en
);

    localparam logic [UW-1:0] LAST_USER = UW'(K - 1);

    xc_state_e state;

    // Requests are honoured only while idle.
    assign cap_en = (state == ST_IDLE) && start;
    assign clr_en = (state == ST_IDLE) && clear;
    assign upd_en = (state == ST_RUN);
    assign busy   = (state == ST_RUN);

    // State, user index and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            user  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        user  <= '0;
                    end
                end
                ST_RUN: begin
                    if (user == LAST_USER) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        user <= user + UW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xcorr_accum.sv
// Top of the sign-steered cross-correlation accumulator. Latches one bit
// interval of real/imaginary chips and user symbols on start, then sweeps
// the users through an N-wide adder bank per part, K cycles per interval.
// Assumes: symbol bit 0 means +1 and 1 means -1; SAMP_W < ACC_W.
module xcorr_accum
    import xcorr_pkg::*;
#(
    parameter int K      = 8,
    parameter int N      = 16,
    parameter int SAMP_W = 8,
    parameter int WINDOW = 64,
    localparam int ACC_W = SAMP_W + $clog2(WINDOW + 1),
    localparam int UW    = (K > 1) ? $clog2(K) : 1,
    localparam int CW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 clear,
    input  logic [N*SAMP_W-1:0]  smp_re,
    input  logic [N*SAMP_W-1:0]  smp_im,
    input  logic [K-1:0]         sym,
    output logic                 busy,
    output logic                 done,
    input  logic [UW-1:0]        rd_user,
    input  logic [CW-1:0]        rd_chip,
    output logic [ACC_W-1:0]     rd_re,
    output logic [ACC_W-1:0]     rd_im
);

    logic          upd_en;
    logic          clr_en;
    logic          cap_en;
    logic [UW-1:0] user;

    logic [N*SAMP_W-1:0] cap_smp [NUM_PARTS];
    logic [K-1:0]        cap_sym;
    logic [ACC_W-1:0]    rd_part [NUM_PARTS];
    logic                neg;

    xcorr_ctrl #(
        .K  (K),
        .UW (UW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .clear  (clear),
        .busy   (busy),
        .done   (done),
        .user   (user),
        .upd_en (upd_en),
        .clr_en (clr_en),
        .cap_en (cap_en)
    );

    // Interval capture so that inputs may change while the sweep runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_smp[PART_RE] <= '0;
            cap_smp[PART_IM] <= '0;
            cap_sym          <= '0;
        end else if (cap_en) begin
            cap_smp[PART_RE] <= smp_re;
            cap_smp[PART_IM] <= smp_im;
            cap_sym          <= sym;
        end
    end

    // Symbol sign of the user being swept steers both parts.
    assign neg = cap_sym[user];

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        logic [N*ACC_W-1:0] cur_row;
        logic [N*ACC_W-1:0] new_row;

        xcorr_lane #(
            .N      (N),
            .SAMP_W (SAMP_W),
            .ACC_W  (ACC_W)
        ) u_lane (
            .neg     (neg),
            .samples (cap_smp[p]),
            .row_in  (cur_row),
            .row_out (new_row)
        );

        xcorr_bank #(
            .K     (K),
            .N     (N),
            .ACC_W (ACC_W),
            .UW    (UW),
            .CW    (CW)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_en),
            .wr_en    (upd_en),
            .cur_user (user),
            .wr_row   (new_row),
            .cur_row  (cur_row),
            .rd_user  (rd_user),
            .rd_chip  (rd_chip),
            .rd_data  (rd_part[p])
        );
    end

    assign rd_re = rd_part[PART_RE];
    assign rd_im = rd_part[PART_IM];

endmodule

// File: rtl/xcorr_accum_chk.sv
// Protocol checker for the accumulator's start/busy/done handshake.
// Assumes: it is bound to xcorr_accum and sees its ports only.
module xcorr_accum_chk #(
    parameter int K = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done
);

    localparam int CNT_W = $clog2(K + 1) + 1;

    logic [CNT_W-1:0] run_cnt;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + CNT_W'(1);
        end else begin
            run_cnt <= '0;
        end
    end

    // R4
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == CNT_W'(K)) && done);

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CNT_W'(K)));

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

bind xcorr_accum xcorr_accum_chk #(.K(K)) u_accum_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
);

// File: tb/tb_xcorr_accum.sv
module tb_xcorr_accum;

    localparam int CLK_PERIOD = 10;
    localparam int K      = 4;
    localparam int N      = 4;
    localparam int SAMP_W = 8;
    localparam int WINDOW = 4;
    localparam int ACC_W  = SAMP_W + $clog2(WINDOW + 1);
    localparam int UW     = 2;
    localparam int CW     = 2;
    localparam int VW     = 1 + K + 2 * N * SAMP_W;
    localparam int ACC_MAX = (1 << (ACC_W - 1)) - 1;
    localparam int ACC_MIN = -(1 << (ACC_W - 1));

    // {clear, sym[3:0], re chips 3..0, im chips 3..0}
    localparam logic [VW-1:0] TBL [6] = '{
        {1'b1, 4'b0000, 32'h7F01_80FE, 32'h0A14_1E28},
        {1'b0, 4'b1010, 32'h807F_00FF, 32'hF6EC_E2D8},
        {1'b0, 4'b0101, 32'h1122_3344, 32'h8080_8080},
        {1'b1, 4'b1111, 32'h05FB_40C0, 32'h7F7F_0102},
        {1'b0, 4'b0011, 32'h8080_7F7F, 32'h0001_FF80},
        {1'b0, 4'b1100, 32'h3CC4_12EE, 32'h09F7_55AB}
    };

    logic                clk = 1'b0;
    logic                rst_n;
    logic                start;
    logic                clear;
    logic [N*SAMP_W-1:0] smp_re;
    logic [N*SAMP_W-1:0] smp_im;
    logic [K-1:0]        sym;
    logic                busy;
    logic                done;
    logic [UW-1:0]       rd_user;
    logic [CW-1:0]       rd_chip;
    logic [ACC_W-1:0]    rd_re;
    logic [ACC_W-1:0]    rd_im;

    int errors = 0;
    int checks = 0;
    int m_re [K][N];
    int m_im [K][N];

    xcorr_accum #(
        .K(K), .N(N), .SAMP_W(SAMP_W), .WINDOW(WINDOW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
        .smp_re(smp_re), .smp_im(smp_im), .sym(sym),
        .busy(busy), .done(done),
        .rd_user(rd_user), .rd_chip(rd_chip), .rd_re(rd_re), .rd_im(rd_im)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int sat(input int v);
        if (v > ACC_MAX) return ACC_MAX;
        if (v < ACC_MIN) return ACC_MIN;
        return v;
    endfunction

    function automatic int chip(input logic [N*SAMP_W-1:0] v, input int n);
        return int'($signed(v[n*SAMP_W +: SAMP_W]));
    endfunction

    // Reference: add or subtract each chip per user symbol, with saturation.
    task automatic model_apply(input logic c, input logic [K-1:0] s,
                               input logic [N*SAMP_W-1:0] re,
                               input logic [N*SAMP_W-1:0] im);
        for (int k = 0; k < K; k++) begin
            for (int n = 0; n < N; n++) begin
                if (c) begin
                    m_re[k][n] = 0;
                    m_im[k][n] = 0;
                end
                m_re[k][n] = sat(m_re[k][n] + (s[k] ? -chip(re, n) : chip(re, n)));
                m_im[k][n] = sat(m_im[k][n] + (s[k] ? -chip(im, n) : chip(im, n)));
            end
        end
    endtask

    task automatic model_zero();
        for (int k = 0; k < K; k++)
            for (int n = 0; n < N; n++) begin
                m_re[k][n] = 0;
                m_im[k][n] = 0;
            end
    endtask

    // Registered read: address at a falling edge, data after the next rise.
    task automatic read_entry(input int k, input int n, output int re, output int im);
        rd_user = UW'(k);
        rd_chip = CW'(n);
        @(posedge clk);
        @(negedge clk);
        re = int'($signed(rd_re));
        im = int'($signed(rd_im));
    endtask

    task automatic compare_all(input string tag);
        int re, im;
        for (int k = 0; k < K; k++)
            for (int n = 0; n < N; n++) begin
                read_entry(k, n, re, im);
                check(tag, re, m_re[k][n]);
                check("R3 imaginary part", im, m_im[k][n]);
            end
    endtask

    // One interval; with disturb set, requests and new inputs arrive mid-sweep (R7).
    task automatic run_window(input logic c, input logic [K-1:0] s,
                              input logic [N*SAMP_W-1:0] re,
                              input logic [N*SAMP_W-1:0] im, input bit disturb);
        @(negedge clk);
        smp_re = re; smp_im = im; sym = s; clear = c; start = 1'b1;
        model_apply(c, s, re, im);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; clear = 1'b0;
        for (int i = 0; i < K; i++) begin
            check("R4 busy during sweep", int'(busy), 1);
            check("R4 done during sweep", int'(done), 0);
            if (disturb && i == 1) begin
                start = 1'b1; clear = 1'b1;
                smp_re = '1; smp_im = {N{8'h55}}; sym = ~s;
            end else begin
                start = 1'b0; clear = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0; clear = 1'b0;
        check("R4 busy after K cycles", int'(busy), 0);
        check("R4 done pulse", int'(done), 1);
        @(posedge clk);
        @(negedge clk);
        check("R4 done single cycle", int'(done), 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int re, im;
        rst_n = 1'b0; start = 1'b0; clear = 1'b0;
        smp_re = '0; smp_im = '0; sym = '0; rd_user = '0; rd_chip = '0;
        model_zero();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
        compare_all("R1 zero after reset");

        // R2/R5/R6: table of intervals walked by one loop
        foreach (TBL[e]) begin
            run_window(TBL[e][VW-1], TBL[e][VW-2 -: K],
                       TBL[e][2*N*SAMP_W-1 -: N*SAMP_W], TBL[e][N*SAMP_W-1:0], 1'b0);
            compare_all(e == 0 ? "R2 add/subtract" :
                        (TBL[e][VW-1] ? "R6 clear then start" : "R5 accumulate"));
        end

        // R9: back-to-back reads, each valid one cycle after its address
        read_entry(3, 2, re, im);
        check("R9 read (3,2)", re, m_re[3][2]);
        read_entry(0, 1, re, im);
        check("R9 read (0,1)", im, m_im[0][1]);

        // R7: start, clear and input changes mid-sweep are ignored
        run_window(1'b0, 4'b0110, 32'h1020_3040, 32'hF0E0_D0C0, 1'b1);
        compare_all("R7 mid-sweep requests ignored");

        // R6: clear alone while idle
        @(negedge clk);
        clear = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
        model_zero();
        check("R6 clear does not start", int'(busy), 0);
        compare_all("R6 clear alone");

        // R8: nine full-scale intervals drive both limits
        for (int w = 0; w < 9; w++) begin
            run_window(w == 0, 4'b0011, {N{8'h80}}, {N{8'h80}}, 1'b0);
        end
        read_entry(0, 0, re, im);
        check("R8 positive limit", re, ACC_MAX);
        read_entry(3, 3, re, im);
        check("R8 negative limit", im, ACC_MIN);
        compare_all("R8 saturation");

        // R1: reset in the middle of a sweep
        @(negedge clk);
        smp_re = {N{8'h11}}; smp_im = {N{8'h22}}; sym = 4'b0101; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_zero();
        check("R1 busy after mid-sweep reset", int'(busy), 0);
        check("R1 done after mid-sweep reset", int'(done), 0);
        compare_all("R1 zero after mid-sweep reset");

        finish_run();
    end

endmodule